// File: doc/BRIEF.md
# Two-Slot Register Renamer

This block sits between decode and the issue window. Each cycle it accepts a group of up to two instructions in program order. It rewrites their architectural register numbers into physical register numbers. Every instruction that writes a register gets a fresh physical register, taken from a circular pool of unused registers. Source operands are looked up in a mapping table that always holds the newest physical name of each architectural register.

The second instruction of a group may depend on the first. A comparator path, running beside the table read, substitutes the first instruction's new register for any matching source of the second one. For each writer the block also reports the physical register that the destination named before this group. The reorder buffer keeps that value and hands it back through the release port at commit, which returns it to the pool.

If the pool cannot cover every writer in the group, the whole group is held and nothing changes. The block has no state machine: the free-pool pointers and the mapping table are its only state.

Top module: `rn_rename2`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i in 0..31, and the pool holds physical registers 32..63 in ascending order, with a count of 32.
- R2: A slot allocates when its valid and write flags are set and its destination is not 0. Allocating slots take registers from the pool head in order: slot 0 first, then slot 1. A slot that does not allocate reports destination 0 and consumes nothing. Two destinations handed out in one group always differ.
- R3: Slot 0 sources report the mapping table entry for their architectural register, which reflects all earlier accepted groups.
- R4: A slot 1 source equal to the destination of an allocating slot 0 reports slot 0's new physical register in the same cycle. Other slot 1 sources read the table.
- R5: An allocating slot reports the destination's mapping as it stood before that slot. For slot 1 with the same destination as an allocating slot 0, this is slot 0's new register. A non-allocating slot reports 0 here.
- R6: When both slots write the same architectural register, the table keeps slot 1's new register afterwards.
- R7: Architectural register 0 is never remapped. Reading it always gives physical register 0, and a write flag with destination 0 allocates nothing.
- R8: The ready output is low exactly when the number of allocating slots exceeds the free count. While it is low, no register is taken and the table does not change.
- R9: A release writes the register at the pool tail. It is handed out only after every register already queued. A release in the same cycle as a group does not help that group.
- R10: The free count equals registers in the pool. In each cycle it falls by the accepted allocations and rises by one per release.
- R11: An invalid slot allocates nothing, writes nothing and feeds no same-cycle substitution to slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_src1 | input | 5 | Slot 0 first source, architectural |
| s0_src2 | input | 5 | Slot 0 second source, architectural |
| s0_dst | input | 5 | Slot 0 destination, architectural |
| s0_wr_dst | input | 1 | Slot 0 writes its destination |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_src1 | input | 5 | Slot 1 first source, architectural |
| s1_src2 | input | 5 | Slot 1 second source, architectural |
| s1_dst | input | 5 | Slot 1 destination, architectural |
| s1_wr_dst | input | 1 | Slot 1 writes its destination |
| grp_ready | output | 1 | Group accepted this cycle; low means stall |
| s0_psrc1 | output | 6 | Slot 0 first source, physical |
| s0_psrc2 | output | 6 | Slot 0 second source, physical |
| s0_pdst | output | 6 | Slot 0 new physical destination, 0 if none |
| s0_pold | output | 6 | Slot 0 previous destination mapping, 0 if none |
| s1_psrc1 | output | 6 | Slot 1 first source, physical |
| s1_psrc2 | output | 6 | Slot 1 second source, physical |
| s1_pdst | output | 6 | Slot 1 new physical destination, 0 if none |
| s1_pold | output | 6 | Slot 1 previous destination mapping, 0 if none |
| rel_valid | input | 1 | Return one physical register to the pool |
| rel_preg | input | 6 | Physical register being returned |
| free_count | output | 6 | Registers currently in the pool |

## Verification
A corrupted table entry shows up on the very next group that reads that architectural register as a source or destination, because every rename output is combinational from the table. A wrong pool pointer or slot shows up on the next allocation as an unexpected physical destination. A wrong count shows up at once on free_count and, near the empty boundary, as a ready level that is wrong in that same cycle. The bench keeps a model of both structures and compares every field of every group, so any such divergence is reported within one group of the cycle in which it is first visible at the ports.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned ARCH_REGS = 32;
    localparam int unsigned PHYS_REGS = 64;

    // mapping table read port assignment
    localparam int unsigned RD_S0_A   = 0;
    localparam int unsigned RD_S0_B   = 1;
    localparam int unsigned RD_S1_A   = 2;
    localparam int unsigned RD_S1_B   = 3;
    localparam int unsigned RD_S0_DST = 4;
    localparam int unsigned RD_S1_DST = 5;
    localparam int unsigned RD_PORTS  = 6;
endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
    parameter int unsigned ARCH_REGS = rn_pkg::ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::PHYS_REGS
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [1:0]                                pop_cnt,
    output logic [$clog2(PHYS_REGS)-1:0]              head0,
    output logic [$clog2(PHYS_REGS)-1:0]              head1,
    input  logic                                      push_en,
    input  logic [$clog2(PHYS_REGS)-1:0]              push_tag,
    output logic [$clog2(PHYS_REGS-ARCH_REGS+1)-1:0]  free_cnt
);
    localparam int unsigned DEPTH = PHYS_REGS - ARCH_REGS;
    localparam int unsigned PW    = $clog2(PHYS_REGS);
    localparam int unsigned IW    = $clog2(DEPTH);
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic [PW-1:0] slots [DEPTH];
    logic [IW-1:0] rd_ptr;
    logic [IW-1:0] wr_ptr;
    logic [CW-1:0] cnt_q;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head0    = slots[rd_ptr];
    assign head1    = slots[bump(rd_ptr)];
    assign free_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                slots[i] <= PW'(int'(ARCH_REGS) + i);
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= CW'(DEPTH);
        end else begin
            if (push_en) begin
                slots[wr_ptr] <= push_tag;
                wr_ptr        <= bump(wr_ptr);
            end
            unique case (pop_cnt)
                2'd1:    rd_ptr <= bump(rd_ptr);
                2'd2:    rd_ptr <= bump(bump(rd_ptr));
                default: rd_ptr <= rd_ptr;
            endcase
            cnt_q <= cnt_q - CW'(pop_cnt) + CW'(push_en);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (cnt_q < CW'(DEPTH)));  // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt != 2'd0) |-> (CW'(pop_cnt) <= cnt_q));  // R8
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int unsigned ARCH_REGS = rn_pkg::ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::PHYS_REGS,
    parameter int unsigned NRD       = rn_pkg::RD_PORTS
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NRD-1:0][$clog2(ARCH_REGS)-1:0]         rd_addr,
    output logic [NRD-1:0][$clog2(PHYS_REGS)-1:0]         rd_data,
    input  logic                                          we0,
    input  logic [$clog2(ARCH_REGS)-1:0]                  wa0,
    input  logic [$clog2(PHYS_REGS)-1:0]                  wd0,
    input  logic                                          we1,
    input  logic [$clog2(ARCH_REGS)-1:0]                  wa1,
    input  logic [$clog2(PHYS_REGS)-1:0]                  wd1
);
    localparam int unsigned AW = $clog2(ARCH_REGS);
    localparam int unsigned PW = $clog2(PHYS_REGS);

    logic [PW-1:0] map_q [ARCH_REGS];

    for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
        assign rd_data[g] = map_q[rd_addr[g]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ARCH_REGS); i++) begin
                map_q[i] <= PW'(i);
            end
        end else begin
            if (we0) begin
                map_q[wa0] <= wd0;
            end
            if (we1) begin
                map_q[wa1] <= wd1;  // younger slot lands last
            end
        end
    end

    AST_ZERO_PINNED_S0: assert property (@(posedge clk) disable iff (!rst_n)
        we0 |-> (wa0 != AW'(0)));  // R7

    AST_ZERO_PINNED_S1: assert property (@(posedge clk) disable iff (!rst_n)
        we1 |-> (wa1 != AW'(0)));  // R7
endmodule

// File: rtl/rn_group_steer.sv
module rn_group_steer #(
    parameter int unsigned ARCH_REGS = rn_pkg::ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::PHYS_REGS
) (
    input  logic                                      s0_valid,
    input  logic                                      s0_wr_dst,
    input  logic [$clog2(ARCH_REGS)-1:0]              s0_dst,
    input  logic                                      s1_valid,
    input  logic                                      s1_wr_dst,
    input  logic [$clog2(ARCH_REGS)-1:0]              s1_src1,
    input  logic [$clog2(ARCH_REGS)-1:0]              s1_src2,
    input  logic [$clog2(ARCH_REGS)-1:0]              s1_dst,
    input  logic [rn_pkg::RD_PORTS-1:0][$clog2(PHYS_REGS)-1:0] tbl,
    input  logic [$clog2(PHYS_REGS)-1:0]              head0,
    input  logic [$clog2(PHYS_REGS)-1:0]              head1,
    input  logic [$clog2(PHYS_REGS-ARCH_REGS+1)-1:0]  free_cnt,
    output logic                                      grp_ready,
    output logic [1:0]                                pop_cnt,
    output logic                                      we0,
    output logic                                      we1,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_psrc1,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_psrc2,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_pdst,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_pold,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_psrc1,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_psrc2,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_pdst,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_pold
);
    import rn_pkg::*;

    localparam int unsigned AW = $clog2(ARCH_REGS);
    localparam int unsigned PW = $clog2(PHYS_REGS);
    localparam int unsigned CW = $clog2(PHYS_REGS - ARCH_REGS + 1);

    logic          alloc0;
    logic          alloc1;
    logic [1:0]    need;
    logic [PW-1:0] new0;
    logic [PW-1:0] new1;
    logic [1:0]    hit_src;
    logic          hit_dst;
    logic [1:0][AW-1:0] s1_srcs;
    logic [1:0][PW-1:0] s1_tbl;
    logic [1:0][PW-1:0] s1_phys;

    assign alloc0 = s0_valid && s0_wr_dst && (s0_dst != AW'(0));
    assign alloc1 = s1_valid && s1_wr_dst && (s1_dst != AW'(0));
    assign need   = {1'b0, alloc0} + {1'b0, alloc1};

    assign grp_ready = (CW'(need) <= free_cnt);
    assign pop_cnt   = grp_ready ? need : 2'd0;

    assign new0 = head0;
    assign new1 = alloc0 ? head1 : head0;

    // same-group dependence on the older slot, in parallel with the table read
    assign s1_srcs = {s1_src2, s1_src1};
    assign s1_tbl  = {tbl[RD_S1_B], tbl[RD_S1_A]};
    for (genvar g = 0; g < 2; g++) begin : g_fwd
        assign hit_src[g] = alloc0 && (s1_srcs[g] == s0_dst);
        assign s1_phys[g] = hit_src[g] ? new0 : s1_tbl[g];
    end
    assign hit_dst = alloc0 && (s1_dst == s0_dst);

    always_comb begin
        s0_psrc1 = tbl[RD_S0_A];
        s0_psrc2 = tbl[RD_S0_B];
        s0_pdst  = alloc0 ? new0 : '0;
        s0_pold  = alloc0 ? tbl[RD_S0_DST] : '0;
        s1_psrc1 = s1_phys[0];
        s1_psrc2 = s1_phys[1];
        s1_pdst  = alloc1 ? new1 : '0;
        s1_pold  = '0;
        if (alloc1) begin
            s1_pold = hit_dst ? new0 : tbl[RD_S1_DST];
        end
    end

    assign we0 = grp_ready && alloc0;
    assign we1 = grp_ready && alloc1;
endmodule

// File: rtl/rn_rename2.sv
module rn_rename2 #(
    parameter int unsigned ARCH_REGS = rn_pkg::ARCH_REGS,
    parameter int unsigned PHYS_REGS = rn_pkg::PHYS_REGS
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      s0_valid,
    input  logic [$clog2(ARCH_REGS)-1:0]              s0_src1,
    input  logic [$clog2(ARCH_REGS)-1:0]              s0_src2,
    input  logic [$clog2(ARCH_REGS)-1:0]              s0_dst,
    input  logic                                      s0_wr_dst,
    input  logic                                      s1_valid,
    input  logic [$clog2(ARCH_REGS)-1:0]              s1_src1,
    input  logic [$clog2(ARCH_REGS)-1:0]              s1_src2,
    input  logic [$clog2(ARCH_REGS)-1:0]              s1_dst,
    input  logic                                      s1_wr_dst,
    output logic                                      grp_ready,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_psrc1,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_psrc2,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_pdst,
    output logic [$clog2(PHYS_REGS)-1:0]              s0_pold,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_psrc1,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_psrc2,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_pdst,
    output logic [$clog2(PHYS_REGS)-1:0]              s1_pold,
    input  logic                                      rel_valid,
    input  logic [$clog2(PHYS_REGS)-1:0]              rel_preg,
    output logic [$clog2(PHYS_REGS-ARCH_REGS+1)-1:0]  free_count
);
    import rn_pkg::*;

    localparam int unsigned AW = $clog2(ARCH_REGS);
    localparam int unsigned PW = $clog2(PHYS_REGS);
    localparam int unsigned CW = $clog2(PHYS_REGS - ARCH_REGS + 1);

    logic [RD_PORTS-1:0][AW-1:0] tbl_addr;
    logic [RD_PORTS-1:0][PW-1:0] tbl_data;
    logic [PW-1:0]               head0;
    logic [PW-1:0]               head1;
    logic [1:0]                  pop_cnt;
    logic [CW-1:0]               cnt;
    logic                        we0;
    logic                        we1;

    always_comb begin
        tbl_addr            = '0;
        tbl_addr[RD_S0_A]   = s0_src1;
        tbl_addr[RD_S0_B]   = s0_src2;
        tbl_addr[RD_S1_A]   = s1_src1;
        tbl_addr[RD_S1_B]   = s1_src2;
        tbl_addr[RD_S0_DST] = s0_dst;
        tbl_addr[RD_S1_DST] = s1_dst;
    end

    rn_map_table #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .NRD       (RD_PORTS)
    ) map_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (tbl_addr),
        .rd_data (tbl_data),
        .we0     (we0),
        .wa0     (s0_dst),
        .wd0     (s0_pdst),
        .we1     (we1),
        .wa1     (s1_dst),
        .wd1     (s1_pdst)
    );

    rn_free_fifo #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS)
    ) pool_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_cnt  (pop_cnt),
        .head0    (head0),
        .head1    (head1),
        .push_en  (rel_valid),
        .push_tag (rel_preg),
        .free_cnt (cnt)
    );

    rn_group_steer #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS)
    ) steer_i (
        .s0_valid  (s0_valid),
        .s0_wr_dst (s0_wr_dst),
        .s0_dst    (s0_dst),
        .s1_valid  (s1_valid),
        .s1_wr_dst (s1_wr_dst),
        .s1_src1   (s1_src1),
        .s1_src2   (s1_src2),
        .s1_dst    (s1_dst),
        .tbl       (tbl_data),
        .head0     (head0),
        .head1     (head1),
        .free_cnt  (cnt),
        .grp_ready (grp_ready),
        .pop_cnt   (pop_cnt),
        .we0       (we0),
        .we1       (we1),
        .s0_psrc1  (s0_psrc1),
        .s0_psrc2  (s0_psrc2),
        .s0_pdst   (s0_pdst),
        .s0_pold   (s0_pold),
        .s1_psrc1  (s1_psrc1),
        .s1_psrc2  (s1_psrc2),
        .s1_pdst   (s1_pdst),
        .s1_pold   (s1_pold)
    );

    assign free_count = cnt;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_ready && !rel_valid) |=> (free_count == $past(free_count)));  // R8

    AST_DISTINCT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ready && (s0_pdst != PW'(0)) && (s1_pdst != PW'(0)))
            |-> (s0_pdst != s1_pdst));  // R2
endmodule

// File: tb/rn_rename2_tb_top.sv
`timescale 1ns/1ps
module rn_rename2_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s0_valid = 1'b0, s0_wr_dst = 1'b0;
    logic [4:0] s0_src1 = '0, s0_src2 = '0, s0_dst = '0;
    logic       s1_valid = 1'b0, s1_wr_dst = 1'b0;
    logic [4:0] s1_src1 = '0, s1_src2 = '0, s1_dst = '0;
    logic       rel_valid = 1'b0;
    logic [5:0] rel_preg = '0;
    logic       grp_ready;
    logic [5:0] s0_psrc1, s0_psrc2, s0_pdst, s0_pold;
    logic [5:0] s1_psrc1, s1_psrc2, s1_pdst, s1_pold;
    logic [5:0] free_count;

    always #2 clk = ~clk;

    rn_rename2 dut_i (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_src1(s0_src1), .s0_src2(s0_src2),
        .s0_dst(s0_dst), .s0_wr_dst(s0_wr_dst),
        .s1_valid(s1_valid), .s1_src1(s1_src1), .s1_src2(s1_src2),
        .s1_dst(s1_dst), .s1_wr_dst(s1_wr_dst),
        .grp_ready(grp_ready),
        .s0_psrc1(s0_psrc1), .s0_psrc2(s0_psrc2), .s0_pdst(s0_pdst), .s0_pold(s0_pold),
        .s1_psrc1(s1_psrc1), .s1_psrc2(s1_psrc2), .s1_pdst(s1_pdst), .s1_pold(s1_pold),
        .rel_valid(rel_valid), .rel_preg(rel_preg), .free_count(free_count)
    );

    typedef struct {
        bit rdy;
        int cnt;
        bit v0;
        bit v1;
        int p0a, p0b, d0, o0;
        int p1a, p1b, d1, o1;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    m_map[32];
    int    m_pool[$];
    int    retire_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    event  sample_ev;

    task automatic chk(input string req, input string ctx, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) act=%0d exp=%0d", req, ctx, act, exp);
        end
    endtask

    // monitor: pop the oldest expectation and compare against the ports
    always @(sample_ev) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk("R8 ready", t, int'(grp_ready), int'(e.rdy));
        chk("R10 count", t, int'(free_count), e.cnt);
        if (e.rdy) begin
            if (e.v0) begin
                chk("R3 s0 src1", t, int'(s0_psrc1), e.p0a);
                chk("R3 s0 src2", t, int'(s0_psrc2), e.p0b);
                chk("R2 s0 dst", t, int'(s0_pdst), e.d0);
                chk("R5 s0 old", t, int'(s0_pold), e.o0);
            end
            if (e.v1) begin
                chk("R4 s1 src1", t, int'(s1_psrc1), e.p1a);
                chk("R4 s1 src2", t, int'(s1_psrc2), e.p1b);
                chk("R2 s1 dst", t, int'(s1_pdst), e.d1);
                chk("R5 s1 old", t, int'(s1_pold), e.o1);
            end
        end
    end

    // driver: apply a group, predict from the model, then advance the model
    task automatic send(input bit v0, input bit w0, input int a0, input int b0, input int d0,
                        input bit v1, input bit w1, input int a1, input int b1, input int d1,
                        input bit rv, input int rp, input string tag);
        exp_t e;
        bit   al0, al1;
        int   need;
        @(negedge clk);
        s0_valid = v0; s0_wr_dst = w0; s0_src1 = 5'(a0); s0_src2 = 5'(b0); s0_dst = 5'(d0);
        s1_valid = v1; s1_wr_dst = w1; s1_src1 = 5'(a1); s1_src2 = 5'(b1); s1_dst = 5'(d1);
        rel_valid = rv; rel_preg = 6'(rp);
        al0  = v0 && w0 && (d0 != 0);
        al1  = v1 && w1 && (d1 != 0);
        need = int'(al0) + int'(al1);
        e.rdy = (need <= m_pool.size());
        e.cnt = m_pool.size();
        e.v0 = v0;
        e.v1 = v1;
        e.d0  = al0 ? m_pool[0] : 0;
        e.d1  = al1 ? (al0 ? m_pool[1] : m_pool[0]) : 0;
        e.p0a = m_map[a0];
        e.p0b = m_map[b0];
        e.o0  = al0 ? m_map[d0] : 0;
        e.p1a = (al0 && a1 == d0) ? e.d0 : m_map[a1];
        e.p1b = (al0 && b1 == d0) ? e.d0 : m_map[b1];
        e.o1  = al1 ? ((al0 && d1 == d0) ? e.d0 : m_map[d1]) : 0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1 -> sample_ev;
        @(posedge clk);
        if (e.rdy) begin
            if (al0) begin
                void'(m_pool.pop_front());
                m_map[d0] = e.d0;
                retire_q.push_back(e.o0);
            end
            if (al1) begin
                void'(m_pool.pop_front());
                m_map[d1] = e.d1;
                retire_q.push_back(e.o1);
            end
        end
        if (rv) m_pool.push_back(rp);
    endtask

    task automatic idle();
        send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_map[i] = i;
        for (int i = 32; i < 64; i++) m_pool.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset count", "reset", int'(free_count), 32);
        chk("R1 reset ready", "reset", int'(grp_ready), 1);

        // identity map after reset, register 0 reads 0, no allocation
        send(1, 0, 5, 7, 0, 1, 0, 0, 31, 0, 0, 0, "R1 identity");
        // two writers take 32 then 33
        send(1, 1, 1, 2, 3, 1, 1, 2, 1, 4, 0, 0, "R2 pair");
        // sources follow earlier groups
        send(1, 0, 3, 4, 0, 1, 0, 4, 3, 0, 0, 0, "R3 newest");
        // slot 1 depends on slot 0 in the same group
        send(1, 1, 3, 9, 5, 1, 1, 5, 5, 8, 0, 0, "R4 bypass");
        send(1, 0, 5, 8, 0, 0, 0, 0, 0, 0, 0, 0, "R4 after");
        // both write the same architectural register
        send(1, 1, 6, 6, 6, 1, 1, 6, 2, 6, 0, 0, "R6 same dst");
        send(1, 0, 6, 0, 0, 1, 0, 6, 6, 0, 0, 0, "R6 table keeps slot1");
        // destination 0 with write flag
        send(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R7 zero dst");
        send(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 zero read");
        // invalid slot 0 gives no substitution and takes nothing
        send(0, 1, 0, 0, 9, 1, 1, 9, 9, 10, 0, 0, "R11 invalid s0");
        send(1, 0, 9, 10, 0, 0, 1, 0, 0, 11, 0, 0, "R11 invalid s1");
        send(1, 0, 11, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 check s1 no write");

        // drain the pool
        begin
            int k = 1;
            while (m_pool.size() >= 2) begin
                send(1, 1, k, 31 - k, k, 1, 1, k, 12, (k % 31) + 1, 0, 0, "R2 drain");
                k = (k % 30) + 1;
            end
        end
        if (m_pool.size() == 1) begin
            send(1, 1, 1, 2, 13, 1, 1, 3, 4, 14, 0, 0, "R8 stall two");
            send(1, 0, 13, 14, 0, 1, 0, 13, 14, 0, 0, 0, "R8 nothing moved");
            send(1, 1, 1, 2, 15, 0, 0, 0, 0, 0, 0, 0, "R8 one fits");
        end
        send(1, 1, 1, 2, 16, 0, 0, 0, 0, 0, 0, 0, "R8 stall empty");
        // release in the same cycle as a stalled group
        send(1, 1, 1, 2, 17, 0, 0, 0, 0, 0, 1, retire_q.pop_front(), "R9 no same-cycle help");
        send(1, 1, 16, 17, 17, 0, 0, 0, 0, 0, 0, 0, "R9 freed reused");

        // return the rest and reuse them in tail order
        while (retire_q.size() > 0) begin
            send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, retire_q.pop_front(), "R10 release");
        end
        for (int j = 0; j < 4; j++) begin
            send(1, 1, 20 + j, 3, 20 + j, 1, 1, 20 + j, 21 + j, 21 + j, 0, 0, "R9 order");
        end
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule